// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations for a processor load/store path. Each lookup supplies a virtual page number, the page offset and whether the access is a read or a write. The page number is compared against every stored tag at once. On a match the entry's permission bits are checked against the access type. The registered result gives one of three outcomes, exactly one per lookup: a hit carrying the translated address, a miss, or a protection violation.

An external agent that walks the page tables installs new translations through a refill port. The block chooses the slot itself: it takes the lowest-numbered empty slot, and once every slot is full it takes a rotating victim. A flush input empties the buffer on a process switch. The page offset is never translated; it is appended to the stored physical page number.

Top module: `xlate_buf`

## Requirements
- R1: The buffer holds 32 entries, and any translation may occupy any entry. After 32 distinct pages are refilled into an empty buffer, all 32 hit.
- R2: A lookup presented with `lk_vld` high at a clock edge produces its result in the cycle right after that edge. `res_vld` is high and, on a hit, `pa` equals {stored 21-bit physical page, offset}.
- R3: The 13-bit page offset appears unchanged in `pa[12:0]`. The physical page occupies `pa[33:13]`.
- R4: When `res_vld` is high, exactly one of `hit`, `miss` and `viol` is high. `miss` is reported when no valid entry holds the looked-up page.
- R5: A read to a matching entry whose read permission is clear, or a write to one whose write permission is clear, raises `viol` and not `hit`. A permitted access to the same entry hits. `lk_wr` = 1 means write and 0 means read.
- R6: A flush invalidates every entry, so every earlier translation misses afterwards.
- R7: A refill goes to the lowest-numbered invalid entry. When all entries are valid, it replaces the entry selected by a victim pointer. The pointer starts at entry 0 after reset and advances by one, with wrap-around, on each such replacement.
- R8: A flush and a refill in the same cycle leave the buffer holding only the refilled translation.
- R9: A lookup uses the contents as they were before its clock edge. A refill in the same cycle is not seen by that lookup but is seen by the next one.
- R10: In a cycle after `lk_vld` was low, `res_vld`, `hit`, `miss` and `viol` are all low. The same holds after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_vld | input | 1 | Lookup request |
| lk_wr | input | 1 | Access type: 1 write, 0 read |
| lk_vpn | input | 30 | Virtual page number to translate |
| lk_off | input | 13 | Page offset |
| rf_en | input | 1 | Refill request |
| rf_vpn | input | 30 | Virtual page number of the new entry |
| rf_ppn | input | 21 | Physical page number of the new entry |
| rf_rd | input | 1 | Read permission of the new entry |
| rf_wr | input | 1 | Write permission of the new entry |
| res_vld | output | 1 | Result valid, one cycle after the lookup |
| hit | output | 1 | Translation found and access permitted |
| miss | output | 1 | No valid entry holds the page |
| viol | output | 1 | Entry found but access type not permitted |
| pa | output | 34 | Physical address {page, offset} |

## Verification
The assertions check on every cycle that the three outcomes are mutually exclusive and that exactly one accompanies a result. They also check that results track the previous cycle's request, that the offset passes through, that a lone flush empties the valid set, and that a refill always leaves some entry valid. Which physical page comes back, how permissions interact with the access type, and which entry a refill evicts can only be shown by the bench's scenarios. The same holds for the visibility of a same-cycle refill and the flush-then-refill ordering, since each depends on a sequence of refills and lookups with known expected pages.

// File: rtl/xlate_buf.sv
module xlate_buf #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 30,
  parameter int PPN_W   = 21,
  parameter int OFF_W   = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   lk_vld,
  input  logic                   lk_wr,
  input  logic [TAG_W-1:0]       lk_vpn,
  input  logic [OFF_W-1:0]       lk_off,
  input  logic                   rf_en,
  input  logic [TAG_W-1:0]       rf_vpn,
  input  logic [PPN_W-1:0]       rf_ppn,
  input  logic                   rf_rd,
  input  logic                   rf_wr,
  output logic                   res_vld,
  output logic                   hit,
  output logic                   miss,
  output logic                   viol,
  output logic [PPN_W+OFF_W-1:0] pa
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld, rd_ok, wr_ok, match, free;
  logic [TAG_W-1:0]   tag [ENTRIES];
  logic [PPN_W-1:0]   ppn [ENTRIES];
  logic [IDX_W-1:0]   sel, vic, rr;
  logic               any, has_free, perm;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (tag[g] == lk_vpn);
  end

  assign any  = |match;
  assign perm = lk_wr ? wr_ok[sel] : rd_ok[sel];
  assign free = flush ? '1 : ~vld;
  assign has_free = |free;

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel = IDX_W'(i);
  end

  always_comb begin
    vic = rr;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (free[i]) vic = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else begin
      if (flush) vld <= '0;
      if (rf_en) begin
        vld[vic] <= 1'b1;
        if (!has_free) rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rf_en) begin
      tag[vic]   <= rf_vpn;
      ppn[vic]   <= rf_ppn;
      rd_ok[vic] <= rf_rd;
      wr_ok[vic] <= rf_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      hit     <= 1'b0;
      miss    <= 1'b0;
      viol    <= 1'b0;
      pa      <= '0;
    end else begin
      res_vld <= lk_vld;
      hit     <= lk_vld && any && perm;
      viol    <= lk_vld && any && !perm;
      miss    <= lk_vld && !any;
      pa      <= {ppn[sel], lk_off};
    end
  end
endmodule

module xlate_buf_chk #(
  parameter int ENTRIES = 32,
  parameter int OFF_W   = 13,
  parameter int PA_W    = 34
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               rf_en,
  input logic               lk_vld,
  input logic [OFF_W-1:0]   lk_off,
  input logic               res_vld,
  input logic               hit,
  input logic               miss,
  input logic               viol,
  input logic [PA_W-1:0]    pa,
  input logic [ENTRIES-1:0] vld
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $countones({hit, miss, viol}) == 1); // R4
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss, viol})); // R4
  AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    lk_vld |=> res_vld); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_vld |=> !res_vld && !hit && !miss && !viol); // R10
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_vld |=> pa[OFF_W-1:0] == $past(lk_off)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !rf_en |=> vld == '0); // R6
  AST_REFILL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_en |=> $countones(vld) >= 1); // R8
endmodule

bind xlate_buf xlate_buf_chk #(.ENTRIES(ENTRIES), .OFF_W(OFF_W), .PA_W(PPN_W + OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .rf_en(rf_en), .lk_vld(lk_vld),
  .lk_off(lk_off), .res_vld(res_vld), .hit(hit), .miss(miss), .viol(viol),
  .pa(pa), .vld(vld)
);

// File: tb/sim_xlate_buf.sv
`timescale 1ns/1ps
module sim_xlate_buf;
  logic clk = 0, rst_n = 0, flush = 0, lk_vld = 0, lk_wr = 0, rf_en = 0, rf_rd = 0, rf_wr = 0;
  logic [29:0] lk_vpn = '0, rf_vpn = '0;
  logic [12:0] lk_off = '0;
  logic [20:0] rf_ppn = '0;
  logic res_vld, hit, miss, viol;
  logic [33:0] pa;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [2:0] O_HIT = 3'b100, O_MISS = 3'b010, O_VIOL = 3'b001;

  always #2.5 clk = ~clk;

  xlate_buf u0 (.clk(clk), .rst_n(rst_n), .flush(flush), .lk_vld(lk_vld), .lk_wr(lk_wr),
    .lk_vpn(lk_vpn), .lk_off(lk_off), .rf_en(rf_en), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
    .rf_rd(rf_rd), .rf_wr(rf_wr), .res_vld(res_vld), .hit(hit), .miss(miss), .viol(viol), .pa(pa));

  function automatic logic [29:0] pg(int i);
    return 30'h2000_0000 + 30'(i) * 30'h123;
  endfunction
  function automatic logic [29:0] qpg(int i);
    return 30'h3000_0000 + 30'(i);
  endfunction
  function automatic logic [20:0] map(logic [29:0] v);
    return v[20:0] ^ 21'h0A5C3;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic refill(logic [29:0] v, logic r, logic w, logic fl);
    @(negedge clk);
    rf_en = 1; rf_vpn = v; rf_ppn = map(v); rf_rd = r; rf_wr = w; flush = fl;
    @(posedge clk);
    @(negedge clk);
    rf_en = 0; flush = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic look(string req, logic [29:0] v, logic [12:0] off, logic w, logic [2:0] exp);
    @(negedge clk);
    lk_vld = 1; lk_vpn = v; lk_off = off; lk_wr = w;
    @(posedge clk);
    @(negedge clk);
    lk_vld = 0;
    check(req, {res_vld, hit, miss, viol}, {1'b1, exp});
    if (exp == O_HIT) check(req, pa, {map(v), off});
  endtask

  task automatic t_reset();
    check("R10 reset", {res_vld, hit, miss, viol}, 4'b0000);
  endtask

  task automatic t_empty();
    look("R4 empty miss", pg(0), 13'h0001, 0, O_MISS);
  endtask

  task automatic t_flush_refill();
    refill(pg(40), 1, 1, 0);
    refill(pg(41), 1, 1, 1);
    look("R8 refilled kept", pg(41), 13'h1ABC, 0, O_HIT);
    look("R8 old gone", pg(40), 13'h0002, 0, O_MISS);
    do_flush();
  endtask

  task automatic t_fill();
    for (int i = 0; i < 32; i++) refill(pg(i), i != 5, i != 3, 0);
    for (int i = 0; i < 32; i++)
      look("R1 R2 R3 fill hit", pg(i), 13'(i * 257 + 3), i == 5, O_HIT);
  endtask

  task automatic t_perm();
    look("R5 write to read-only", pg(3), 13'h0010, 1, O_VIOL);
    look("R5 read to read-only", pg(3), 13'h0011, 0, O_HIT);
    look("R5 read to write-only", pg(5), 13'h0012, 0, O_VIOL);
    look("R5 write to write-only", pg(5), 13'h1FFF, 1, O_HIT);
  endtask

  task automatic t_rr();
    refill(qpg(0), 1, 1, 0);
    look("R7 victim 0 evicted", pg(0), 13'h0, 0, O_MISS);
    look("R7 new in slot", qpg(0), 13'h0777, 0, O_HIT);
    look("R7 entry 1 kept", pg(1), 13'h0005, 0, O_HIT);
    refill(qpg(1), 1, 1, 0);
    look("R7 victim 1 evicted", pg(1), 13'h0, 0, O_MISS);
    look("R7 entry 2 kept", pg(2), 13'h0006, 1, O_HIT);
  endtask

  task automatic t_flush();
    do_flush();
    look("R6 flushed page", pg(2), 13'h0, 0, O_MISS);
    look("R6 flushed refill", qpg(0), 13'h0, 0, O_MISS);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    rf_en = 1; rf_vpn = qpg(9); rf_ppn = map(qpg(9)); rf_rd = 1; rf_wr = 1;
    lk_vld = 1; lk_vpn = qpg(9); lk_off = 13'h0042; lk_wr = 0;
    @(posedge clk);
    @(negedge clk);
    rf_en = 0; lk_vld = 0;
    check("R9 same-cycle refill unseen", {res_vld, hit, miss, viol}, {1'b1, O_MISS});
    look("R9 seen next", qpg(9), 13'h0043, 0, O_HIT);
  endtask

  task automatic t_idle();
    @(negedge clk);
    lk_vld = 0; lk_vpn = qpg(9);
    @(negedge clk);
    check("R10 idle quiet", {res_vld, hit, miss, viol}, 4'b0000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_empty();
    t_flush_refill();
    t_fill();
    t_perm();
    t_rr();
    t_flush();
    t_same_cycle();
    t_idle();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule